// File: doc/BRIEF.md
# Gigabit Ethernet Idle Ordered-Set Rewriter

This block sits directly in front of an 8b/10b encoder on a gigabit Ethernet transmit path. Each cycle it takes one code group (an 8-bit value and a control flag) together with the encoder's current running disparity. It returns the code group on a registered output one cycle later. When a data code group follows a comma (K28.5), the block swaps the data byte for one of two fixed idle bytes. The choice depends on the disparity that stood before the comma, so every idle ordered set leaves the encoder with negative running disparity. Configuration ordered sets and control code groups that follow a comma are passed through untouched.

After transmit reset is released, the block drives a parameterised run of at least three commas before any user code group is accepted. During that run it holds the source off through a ready signal, so user data waits and is not lost.

Top module: `gbe_idle_rewriter`

## Requirements
- R1: While `tx_rst` is high, the output at every clock is the comma (code 0xBC with control flag 1), and `in_ready` is low.
- R2: After `tx_rst` falls, `in_ready` stays low for exactly PREAMBLE_LEN clock edges (PREAMBLE_LEN must be at least 3). Every output in that span is a comma. Once `in_ready` rises it stays high until the next reset.
- R3: A code group accepted at a clock edge (`in_ready` high) appears on `out_code`/`out_ctl` immediately after that edge: one cycle of latency.
- R4: A data code group accepted directly after an accepted comma is output as 0xC5 (D5.6, control 0) when `rd_pos` was 1 in the cycle the comma was accepted.
- R5: A data code group accepted directly after an accepted comma is output as 0x50 (D16.2, control 0) when `rd_pos` was 0 in the cycle the comma was accepted.
- R6: Data bytes 0xB5 (D21.5) and 0x42 (D2.2) following a comma pass through unchanged.
- R7: A control code group (control flag 1) is never altered, including one that follows a comma.
- R8: Only the code group directly after a comma is rewritten. A data byte 0xBC with control flag 0 is not a comma, and data after any non-comma passes unchanged.
- R9: Using a disparity model in which a comma and 0x50 flip disparity and every other byte keeps it, disparity is negative after every rewritten idle set.
- R10: Commas sent during the preamble, and inputs presented while `in_ready` is low, do not arm the rewrite. The first user code group after reset is passed unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| tx_rst | input | 1 | Synchronous transmit reset, active high |
| in_code | input | 8 | Incoming code group byte |
| in_ctl | input | 1 | Control flag of the incoming code group |
| rd_pos | input | 1 | Encoder running disparity, 1 = positive |
| in_ready | output | 1 | High when the incoming code group is accepted this cycle |
| out_code | output | 8 | Outgoing code group byte, registered |
| out_ctl | output | 1 | Control flag of the outgoing code group |

## Verification
The bench builds the block with PREAMBLE_LEN set to 4 instead of the default 3. This shows that the length of the hold-off depends on the parameter and is not fixed at three edges. It exercises the preamble counter through a non-minimal count. It also lets the bench confirm that a comma offered during the longer hold-off never arms a rewrite. The default of 3 still elaborates through the same generate checks.

// File: rtl/gbe_idle_pkg.sv
package gbe_idle_pkg;

   localparam int CG_W = 8;

   typedef struct packed {
      logic            ctl;
      logic [CG_W-1:0] code;
   } cgrp_t;

   localparam logic [CG_W-1:0] COMMA_CODE = 8'hBC;  // K28.5
   localparam logic [CG_W-1:0] IDLE1_DATA = 8'hC5;  // D5.6
   localparam logic [CG_W-1:0] IDLE2_DATA = 8'h50;  // D16.2

   // data bytes that mark a configuration ordered set after a comma
   localparam int                   N_CFG     = 2;
   localparam logic [N_CFG*CG_W-1:0] CFG_CODES = {8'h42, 8'hB5};

   localparam cgrp_t COMMA_GRP = '{ctl: 1'b1, code: COMMA_CODE};

   function automatic logic is_comma(cgrp_t g);
      return g.ctl && (g.code == COMMA_CODE);
   endfunction

endpackage

// File: rtl/idle_preamble_ctr.sv
module idle_preamble_ctr #(
   parameter int PREAMBLE_LEN = 3
) (
   input  logic clk,
   input  logic tx_rst,
   output logic done
);
   localparam int CNT_W = $clog2(PREAMBLE_LEN + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PREAMBLE_LEN);

   generate
      if (PREAMBLE_LEN < 3) begin : g_len_bad
         $error("idle_preamble_ctr: PREAMBLE_LEN must be at least 3");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (tx_rst)
         cnt <= '0;
      else if (cnt != LAST)
         cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LAST);

   // R2: once released, hold-off never returns without a reset
   assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (tx_rst)
      done |=> done);

endmodule

// File: rtl/idle_comma_tracker.sv
module idle_comma_tracker
   import gbe_idle_pkg::*;
(
   input  logic  clk,
   input  logic  tx_rst,
   input  logic  accept,
   input  cgrp_t grp,
   input  logic  rd_pos,
   output logic  armed,
   output logic  rd_before_pos
);
   always_ff @(posedge clk) begin
      if (tx_rst) begin
         armed         <= 1'b0;
         rd_before_pos <= 1'b0;
      end else if (accept) begin
         armed <= is_comma(grp);
         if (is_comma(grp))
            rd_before_pos <= rd_pos;
      end
   end

   // R10: nothing presented during hold-off can arm a rewrite
   assert_no_arm_in_holdoff_R10: assert property (@(posedge clk) disable iff (tx_rst)
      !accept |=> !armed);

endmodule

// File: rtl/idle_substitute.sv
module idle_substitute
   import gbe_idle_pkg::*;
(
   input  cgrp_t grp_in,
   input  logic  armed,
   input  logic  rd_before_pos,
   output cgrp_t grp_out
);
   logic [N_CFG-1:0] cfg_hit;

   generate
      for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
         assign cfg_hit[i] = !grp_in.ctl && (grp_in.code == CFG_CODES[i*CG_W +: CG_W]);
      end
   endgenerate

   always_comb begin
      grp_out = grp_in;
      if (armed && !grp_in.ctl && !(|cfg_hit))
         grp_out.code = rd_before_pos ? IDLE1_DATA : IDLE2_DATA;
   end

   // R7: control code groups leave this stage untouched
   always_comb begin
      if (grp_in.ctl)
         assert_ctl_untouched_R7: assert (grp_out == grp_in);
   end

endmodule

// File: rtl/gbe_idle_rewriter.sv
module gbe_idle_rewriter
   import gbe_idle_pkg::*;
#(
   parameter int PREAMBLE_LEN = 3
) (
   input  logic       clk,
   input  logic       tx_rst,
   input  logic [7:0] in_code,
   input  logic       in_ctl,
   input  logic       rd_pos,
   output logic       in_ready,
   output logic [7:0] out_code,
   output logic       out_ctl
);
   generate
      if (CG_W != 8) begin : g_width_bad
         $error("gbe_idle_rewriter: code group width must be 8");
      end
   endgenerate

   cgrp_t in_grp, sub_grp, out_q;
   logic  armed, rd_before_pos, ready;

   assign in_grp = '{ctl: in_ctl, code: in_code};

   idle_preamble_ctr #(.PREAMBLE_LEN(PREAMBLE_LEN)) i_ctr (
      .clk    (clk),
      .tx_rst (tx_rst),
      .done   (ready)
   );

   idle_comma_tracker i_trk (
      .clk           (clk),
      .tx_rst        (tx_rst),
      .accept        (ready),
      .grp           (in_grp),
      .rd_pos        (rd_pos),
      .armed         (armed),
      .rd_before_pos (rd_before_pos)
   );

   idle_substitute i_sub (
      .grp_in        (in_grp),
      .armed         (armed),
      .rd_before_pos (rd_before_pos),
      .grp_out       (sub_grp)
   );

   always_ff @(posedge clk) begin
      if (tx_rst || !ready)
         out_q <= COMMA_GRP;
      else
         out_q <= sub_grp;
   end

   assign in_ready = ready;
   assign out_code = out_q.code;
   assign out_ctl  = out_q.ctl;

   // port-level views for the properties below
   logic comma_at_in, cfg_at_in, plain_at_in;
   assign comma_at_in = in_ctl && (in_code == 8'hBC);
   assign cfg_at_in   = !in_ctl && ((in_code == 8'hB5) || (in_code == 8'h42));
   assign plain_at_in = !in_ctl && !cfg_at_in;

   assert_rst_comma_R1: assert property (@(posedge clk)
      tx_rst |=> (out_ctl && out_code == 8'hBC && !in_ready));

   assert_holdoff_comma_R2: assert property (@(posedge clk) disable iff (tx_rst)
      !in_ready |=> (out_ctl && out_code == 8'hBC));

   assert_idle1_R4: assert property (@(posedge clk) disable iff (tx_rst)
      (in_ready && comma_at_in && rd_pos) ##1 (in_ready && plain_at_in)
      |=> (!out_ctl && out_code == 8'hC5));

   assert_idle2_R5: assert property (@(posedge clk) disable iff (tx_rst)
      (in_ready && comma_at_in && !rd_pos) ##1 (in_ready && plain_at_in)
      |=> (!out_ctl && out_code == 8'h50));

   assert_cfg_pass_R6: assert property (@(posedge clk) disable iff (tx_rst)
      (in_ready && comma_at_in) ##1 (in_ready && cfg_at_in)
      |=> (!out_ctl && out_code == $past(in_code)));

   assert_ctl_pass_R7: assert property (@(posedge clk) disable iff (tx_rst)
      (in_ready && in_ctl) |=> (out_ctl && out_code == $past(in_code)));

   assert_no_rewrite_R8: assert property (@(posedge clk) disable iff (tx_rst)
      (in_ready && !comma_at_in) ##1 (in_ready && !in_ctl)
      |=> (!out_ctl && out_code == $past(in_code)));

endmodule

// File: tb/test_gbe_idle_rewriter.sv
module test_gbe_idle_rewriter;

   localparam int PLEN = 4;
   localparam int NV   = 18;

   typedef struct packed {
      logic       ic;
      logic [7:0] iv;
      logic       ec;
      logic [7:0] ev;
   } vec_t;

   // input group -> expected output group
   localparam vec_t VECS [NV] = '{
      {1'b1, 8'hBC, 1'b1, 8'hBC},
      {1'b0, 8'h6E, 1'b0, 8'hC5},
      {1'b1, 8'hBC, 1'b1, 8'hBC},
      {1'b0, 8'h18, 1'b0, 8'h50},
      {1'b1, 8'hBC, 1'b1, 8'hBC},
      {1'b0, 8'hEF, 1'b0, 8'h50},
      {1'b1, 8'hBC, 1'b1, 8'hBC},
      {1'b0, 8'hB5, 1'b0, 8'hB5},
      {1'b1, 8'hBC, 1'b1, 8'hBC},
      {1'b0, 8'h42, 1'b0, 8'h42},
      {1'b1, 8'hBC, 1'b1, 8'hBC},
      {1'b1, 8'hFB, 1'b1, 8'hFB},
      {1'b0, 8'h33, 1'b0, 8'h33},
      {1'b0, 8'hBC, 1'b0, 8'hBC},
      {1'b0, 8'h77, 1'b0, 8'h77},
      {1'b1, 8'hBC, 1'b1, 8'hBC},
      {1'b1, 8'hBC, 1'b1, 8'hBC},
      {1'b0, 8'h00, 1'b0, 8'h50}
   };

   logic       clk = 1'b0;
   logic       tx_rst;
   logic [7:0] in_code;
   logic       in_ctl;
   logic       rd_pos;
   logic       in_ready;
   logic [7:0] out_code;
   logic       out_ctl;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   gbe_idle_rewriter #(.PREAMBLE_LEN(PLEN)) i_gbe_idle_rewriter (
      .clk      (clk),
      .tx_rst   (tx_rst),
      .in_code  (in_code),
      .in_ctl   (in_ctl),
      .rd_pos   (rd_pos),
      .in_ready (in_ready),
      .out_code (out_code),
      .out_ctl  (out_ctl)
   );

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog expired, all requirements");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wait_ready(output int edges);
      edges = 0;
      while (!in_ready && edges < 50) begin
         @(negedge clk);
         edges++;
         chk("R2 hold-off comma", {out_ctl, out_code}, {1'b1, 8'hBC});
      end
   endtask

   initial begin
      int   n;
      logic rd;
      string tag;
      tx_rst  = 1'b1;
      in_ctl  = 1'b1;
      in_code = 8'hBC;
      rd_pos  = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset output", {out_ctl, out_code}, {1'b1, 8'hBC});
      chk("R1 reset ready", {8'h0, in_ready}, 9'h0);

      // R10: a comma presented during hold-off must not arm a rewrite
      in_ctl = 1'b1; in_code = 8'hBC; rd_pos = 1'b1;
      tx_rst = 1'b0;
      wait_ready(n);
      chk("R2 hold-off length", 9'(n), 9'(PLEN));
      in_ctl = 1'b0; in_code = 8'h6E;
      @(negedge clk);
      chk("R10 first user group", {out_ctl, out_code}, {1'b0, 8'h6E});
      chk("R2 ready sticky", {8'h0, in_ready}, 9'h1);

      // table walk; each result sampled one edge after drive (R3)
      rd = 1'b1;
      for (int i = 0; i < NV; i++) begin
         in_ctl  = VECS[i].ic;
         in_code = VECS[i].iv;
         rd_pos  = rd;
         @(negedge clk);
         if (VECS[i].ec)                                     tag = "R7";
         else if (VECS[i].ev == 8'hC5)                       tag = "R4";
         else if (VECS[i].ev == 8'h50)                       tag = "R5";
         else if (VECS[i].ev == 8'hB5 || VECS[i].ev == 8'h42) tag = "R6";
         else                                                tag = "R8";
         chk($sformatf("%s R3 vector %0d", tag, i), {out_ctl, out_code},
             {VECS[i].ec, VECS[i].ev});
         if (VECS[i].ec && VECS[i].ev == 8'hBC)       rd = ~rd;
         else if (!VECS[i].ec && VECS[i].ev == 8'h50) rd = ~rd;
         if (!VECS[i].ec && (VECS[i].ev == 8'hC5 || VECS[i].ev == 8'h50))
            chk($sformatf("R9 disparity after idle %0d", i), {8'h0, rd}, 9'h0);
      end

      // reset between a comma and its data: tracker must be cleared (R10)
      in_ctl = 1'b1; in_code = 8'hBC; rd_pos = 1'b1;
      @(negedge clk);
      tx_rst = 1'b1;
      in_ctl = 1'b0; in_code = 8'h18;
      @(negedge clk);
      chk("R1 mid-stream reset output", {out_ctl, out_code}, {1'b1, 8'hBC});
      chk("R1 mid-stream reset ready", {8'h0, in_ready}, 9'h0);
      tx_rst = 1'b0;
      wait_ready(n);
      chk("R2 hold-off length again", 9'(n), 9'(PLEN));
      @(negedge clk);
      chk("R10 no rewrite after reset", {out_ctl, out_code}, {1'b0, 8'h18});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule